// File: doc/BRIEF.md
# Keyed Index/Data Configuration Port

This block is a legacy host configuration interface made of two byte-wide I/O locations inside a two-byte window: an index location at the window base and a data location at base+1. A strap input chooses the base, 0x2E or 0x4E. The interface stays locked after reset. It opens only after the host writes the opening key byte 0x87 to the index location twice in a row. While it is open, an index write selects a configuration register, and reads or writes at the data location reach that register. Writing 0xAA to the index location closes the interface again. The host gets no acknowledgement of opening, so software simply assumes the key worked.

Registers below 0x30 are global. They hold a bank (logical device) selector, a read-only identity pair, and a miscellaneous register that reports the strap. Registers at 0x30 and above are banked. Each logical device has its own activation bit and its own small block of configuration bytes, and these are presented as outputs to the logical devices downstream. The host bus uses simple strobes: a write takes effect on the clock edge where the write strobe is high, and read data is combinational while the read strobe is high.

Top module: `keyed_cfg_port`

## Requirements
- R1: The window base is 0x2E when `base_sel` is 0 and 0x4E when it is 1. Address bit 0 = 0 is the index location and bit 0 = 1 is the data location. Accesses outside the window have no effect, and reads there return 0xFF.
- R2: Two consecutive index writes of 0x87 open the interface, and `cfg_open` rises on the clock after the second one. Data-location accesses between the two keys do not break the sequence.
- R3: While the interface is locked, an index write of any value other than 0x87 returns the key detector to idle, so two fresh 0x87 writes are needed.
- R4: While the interface is open, an index write of 0xAA locks it and leaves the selected index unchanged.
- R5: While the interface is locked, reads at both locations return 0xFF, and data writes change no register.
- R6: While the interface is open, an index write selects a register (any value but 0xAA), an index read returns the selected index, and data accesses reach the selected register.
- R7: After reset the interface is locked, and the index, bank selector, miscellaneous register, activation bits and bank bytes are all 0.
- R8: Register 0x20 reads the parameter DEV_ID and 0x21 reads DEV_REV. Writes to either have no effect.
- R9: Bit 6 of register 0x26 always reads `base_sel`. Its other seven bits are read/write storage.
- R10: Register 0x07 is the read/write bank selector, shown on `ldn`. Registers at 0x30 and above address the selected bank only. With a selector of NUM_BANKS or more, banked reads return 0x00 and banked writes are ignored.
- R11: Register 0x30 of a bank stores only bit 0, which drives `dev_active[bank]`. The other bits read 0.
- R12: Registers 0xF0 to 0xF0+BANK_REGS-1 are read/write bytes per bank. Byte r of bank b appears on `dev_cfg[(b*BANK_REGS+r)*8 +: 8]`. Writing one bank leaves the other banks unchanged.
- R13: Any other register reads 0x00, and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_addr | input | 16 | Host I/O address |
| io_wr | input | 1 | Host write strobe |
| io_rd | input | 1 | Host read strobe |
| io_wdata | input | 8 | Host write data |
| io_rdata | output | 8 | Host read data (0xFF when idle or not decoded) |
| base_sel | input | 1 | Base strap: 0 selects 0x2E, 1 selects 0x4E |
| cfg_open | output | 1 | Interface is unlocked |
| ldn | output | 8 | Selected bank number |
| dev_active | output | NUM_BANKS | Activation bit per bank |
| dev_cfg | output | NUM_BANKS*BANK_REGS*8 | Packed configuration bytes for all banks |

## Verification
The hardest situation to reach is a broken key sequence in which the second 0x87 arrives after an intervening index byte, or after data-location traffic that must not count as a break. Random stimulus that draws index bytes uniformly would almost never produce this. The bench therefore weights index writes heavily toward 0x87 and 0xAA, mixes in data accesses and out-of-window addresses, and adds directed sequences that break the key at each position. A reference model built from the requirements tracks the lock state and every register, and each read and output is compared with it.

// File: rtl/keyed_cfg_port.sv
module keyed_cfg_port #(
  parameter int          NUM_BANKS = 10,
  parameter int          BANK_REGS = 8,
  parameter logic [7:0]  DEV_ID    = 8'h52,
  parameter logic [7:0]  DEV_REV   = 8'h17,
  parameter logic [15:0] BASE_LO   = 16'h002E,
  parameter logic [15:0] BASE_HI   = 16'h004E
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [15:0]                      io_addr,
  input  logic                             io_wr,
  input  logic                             io_rd,
  input  logic [7:0]                       io_wdata,
  output logic [7:0]                       io_rdata,
  input  logic                             base_sel,
  output logic                             cfg_open,
  output logic [7:0]                       ldn,
  output logic [NUM_BANKS-1:0]             dev_active,
  output logic [NUM_BANKS*BANK_REGS*8-1:0] dev_cfg
);
  localparam logic [7:0] KEY_OPEN  = 8'h87;
  localparam logic [7:0] KEY_CLOSE = 8'hAA;
  localparam logic [7:0] A_LDN     = 8'h07;
  localparam logic [7:0] A_ID      = 8'h20;
  localparam logic [7:0] A_REV     = 8'h21;
  localparam logic [7:0] A_MISC    = 8'h26;
  localparam logic [7:0] A_ACT     = 8'h30;
  localparam int         CFG_LO    = 240;
  localparam int         LW        = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
  localparam int         OW        = (BANK_REGS > 1) ? $clog2(BANK_REGS) : 1;

  typedef enum logic [1:0] {S_IDLE, S_HALF, S_OPEN} key_st_t;

  key_st_t     st_q;
  logic [7:0]  index_q;
  logic [7:0]  ldn_q;
  logic [7:0]  misc_q;
  logic [NUM_BANKS-1:0] act_q;
  logic [7:0]  mem_q [NUM_BANKS][BANK_REGS];

  logic [15:0] base;
  logic        hit, idx_wr, dat_wr, bank_ok, bank_reg;
  logic [LW-1:0] bank;
  logic [7:0]  off_full;
  logic [OW-1:0] off;

  assign base     = base_sel ? BASE_HI : BASE_LO;
  assign hit      = (io_addr[15:1] == base[15:1]);
  assign idx_wr   = io_wr && hit && !io_addr[0];
  assign dat_wr   = io_wr && hit && io_addr[0] && (st_q == S_OPEN);
  assign bank_ok  = (int'(ldn_q) < NUM_BANKS);
  assign bank     = ldn_q[LW-1:0];
  assign bank_reg = (int'(index_q) >= CFG_LO) && (int'(index_q) < CFG_LO + BANK_REGS);
  assign off_full = index_q - 8'(CFG_LO);
  assign off      = off_full[OW-1:0];

  assign cfg_open   = (st_q == S_OPEN);
  assign ldn        = ldn_q;
  assign dev_active = act_q;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    for (genvar r = 0; r < BANK_REGS; r++) begin : g_reg
      assign dev_cfg[(b*BANK_REGS+r)*8 +: 8] = mem_q[b][r];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      index_q <= '0;
      ldn_q   <= '0;
      misc_q  <= '0;
      act_q   <= '0;
      for (int b = 0; b < NUM_BANKS; b++)
        for (int r = 0; r < BANK_REGS; r++)
          mem_q[b][r] <= '0;
    end else begin
      if (idx_wr) begin
        case (st_q)
          S_IDLE: st_q <= (io_wdata == KEY_OPEN) ? S_HALF : S_IDLE;
          S_HALF: st_q <= (io_wdata == KEY_OPEN) ? S_OPEN : S_IDLE;
          default: begin
            if (io_wdata == KEY_CLOSE) st_q <= S_IDLE;
            else index_q <= io_wdata;
          end
        endcase
      end
      if (dat_wr) begin
        if (index_q == A_LDN) ldn_q <= io_wdata;
        else if (index_q == A_MISC) misc_q <= io_wdata;
        else if (index_q == A_ACT) begin
          if (bank_ok) act_q[bank] <= io_wdata[0];
        end else if (bank_reg && bank_ok) mem_q[bank][off] <= io_wdata;
      end
    end
  end

  always_comb begin
    io_rdata = 8'hFF;
    if (io_rd && hit && st_q == S_OPEN) begin
      if (!io_addr[0]) io_rdata = index_q;
      else begin
        case (index_q)
          A_LDN:  io_rdata = ldn_q;
          A_ID:   io_rdata = DEV_ID;
          A_REV:  io_rdata = DEV_REV;
          A_MISC: io_rdata = {misc_q[7], base_sel, misc_q[5:0]};
          A_ACT:  io_rdata = bank_ok ? {7'b0, act_q[bank]} : 8'h00;
          default: io_rdata = (bank_reg && bank_ok) ? mem_q[bank][off] : 8'h00;
        endcase
      end
    end
  end
endmodule

module keyed_cfg_port_chk #(
  parameter int          NUM_BANKS = 10,
  parameter int          BANK_REGS = 8,
  parameter logic [15:0] BASE_LO   = 16'h002E,
  parameter logic [15:0] BASE_HI   = 16'h004E
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic [15:0]                      io_addr,
  input logic                             io_wr,
  input logic                             io_rd,
  input logic [7:0]                       io_wdata,
  input logic [7:0]                       io_rdata,
  input logic                             base_sel,
  input logic                             cfg_open,
  input logic [7:0]                       ldn,
  input logic [NUM_BANKS-1:0]             dev_active,
  input logic [NUM_BANKS*BANK_REGS*8-1:0] dev_cfg
);
  logic [15:0] wbase;
  logic        in_win, iw, dw;
  assign wbase  = base_sel ? BASE_HI : BASE_LO;
  assign in_win = (io_addr[15:1] == wbase[15:1]);
  assign iw     = io_wr && in_win && !io_addr[0];
  assign dw     = io_wr && in_win && io_addr[0];

  // R5
  locked_read_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && !cfg_open) |-> (io_rdata == 8'hFF));

  // R5
  locked_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_open |=> ($stable(ldn) && $stable(dev_active) && $stable(dev_cfg)));

  // R4
  close_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_open && iw && io_wdata == 8'hAA) |=> !cfg_open);

  // R2
  open_needs_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_open) |-> $past(iw && io_wdata == 8'h87));

  // R3
  bad_key_stays_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_open && iw && io_wdata != 8'h87) |=> !cfg_open);

  // R11
  active_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(dw && cfg_open) |=> $stable(dev_active));

  // R1
  outside_read_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && !in_win) |-> (io_rdata == 8'hFF));
endmodule

bind keyed_cfg_port keyed_cfg_port_chk #(
  .NUM_BANKS(NUM_BANKS), .BANK_REGS(BANK_REGS), .BASE_LO(BASE_LO), .BASE_HI(BASE_HI)
) u_chk (.*);

// File: tb/tb_keyed_cfg_port.sv
module tb_keyed_cfg_port;
  localparam int NB = 10;
  localparam int BR = 8;
  localparam int DW = NB*BR*8;
  localparam logic [7:0] ID  = 8'h52;
  localparam logic [7:0] REV = 8'h17;

  logic clk = 0, rst_n = 0;
  logic [15:0] io_addr = 0;
  logic io_wr = 0, io_rd = 0, base_sel = 0;
  logic [7:0] io_wdata = 0;
  logic [7:0] io_rdata, ldn;
  logic cfg_open;
  logic [NB-1:0] dev_active;
  logic [DW-1:0] dev_cfg;

  int checks = 0, fails = 0;
  bit done = 0;

  int m_st;
  logic [7:0] m_idx, m_ldn, m_misc;
  logic [NB-1:0] m_act;
  logic [7:0] m_cfg [NB][BR];

  always #2 clk = ~clk;

  keyed_cfg_port dut (.*);

  function automatic logic [15:0] cur_base();
    return base_sel ? 16'h004E : 16'h002E;
  endfunction

  function automatic bit in_win(logic [15:0] a);
    logic [15:0] b = cur_base();
    return a[15:1] == b[15:1];
  endfunction

  function automatic logic [7:0] exp_read(logic [15:0] a);
    if (!in_win(a) || m_st != 2) return 8'hFF;
    if (!a[0]) return m_idx;
    if (m_idx == 8'h07) return m_ldn;
    if (m_idx == 8'h20) return ID;
    if (m_idx == 8'h21) return REV;
    if (m_idx == 8'h26) return {m_misc[7], base_sel, m_misc[5:0]};
    if (m_idx == 8'h30) return (int'(m_ldn) < NB) ? {7'b0, m_act[m_ldn]} : 8'h00;
    if (int'(m_idx) >= 240 && int'(m_idx) < 240 + BR && int'(m_ldn) < NB)
      return m_cfg[m_ldn][int'(m_idx) - 240];
    return 8'h00;
  endfunction

  function automatic void model_wr(logic [15:0] a, logic [7:0] d);
    if (!in_win(a)) return;
    if (!a[0]) begin
      if (m_st == 0) m_st = (d == 8'h87) ? 1 : 0;
      else if (m_st == 1) m_st = (d == 8'h87) ? 2 : 0;
      else if (d == 8'hAA) m_st = 0;
      else m_idx = d;
    end else if (m_st == 2) begin
      if (m_idx == 8'h07) m_ldn = d;
      else if (m_idx == 8'h26) m_misc = d;
      else if (m_idx == 8'h30) begin
        if (int'(m_ldn) < NB) m_act[m_ldn] = d[0];
      end else if (int'(m_idx) >= 240 && int'(m_idx) < 240 + BR && int'(m_ldn) < NB)
        m_cfg[m_ldn][int'(m_idx) - 240] = d;
    end
  endfunction

  function automatic logic [DW-1:0] exp_cfg();
    logic [DW-1:0] v;
    for (int b = 0; b < NB; b++)
      for (int r = 0; r < BR; r++) v[(b*BR+r)*8 +: 8] = m_cfg[b][r];
    return v;
  endfunction

  task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_outs(string tag);
    chk({tag, " open"}, DW'(cfg_open), DW'(m_st == 2));
    chk({tag, " ldn"}, DW'(ldn), DW'(m_ldn));
    chk({tag, " active"}, DW'(dev_active), DW'(m_act));
    chk({tag, " cfg"}, dev_cfg, exp_cfg());
  endtask

  task automatic do_wr(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1;
    @(posedge clk);
    model_wr(a, d);
    @(negedge clk);
    io_wr = 0;
  endtask

  task automatic do_rd(logic [15:0] a, string tag);
    @(negedge clk);
    io_addr = a; io_rd = 1;
    #1;
    chk(tag, DW'(io_rdata), DW'(exp_read(a)));
    @(negedge clk);
    io_rd = 0;
  endtask

  task automatic idx(logic [7:0] d); do_wr(cur_base(), d); endtask
  task automatic dat(logic [7:0] d); do_wr(cur_base() | 16'h1, d); endtask
  task automatic rdd(string tag); do_rd(cur_base() | 16'h1, tag); endtask
  task automatic unlock(); idx(8'h87); idx(8'h87); endtask

  function automatic logic [7:0] pick_idx();
    int s = $urandom_range(0, 15);
    if (s < 5) return 8'h87;
    if (s < 7) return 8'hAA;
    if (s == 7) return 8'h07;
    if (s == 8) return 8'h30;
    if (s == 9) return 8'h26;
    if (s == 10) return 8'h20;
    if (s < 14) return 8'hF0 + 8'($urandom_range(0, 9));
    return 8'($urandom);
  endfunction

  initial begin
    #(4*200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234abcd));
    m_st = 0; m_idx = 0; m_ldn = 0; m_misc = 0; m_act = 0;
    for (int b = 0; b < NB; b++) for (int r = 0; r < BR; r++) m_cfg[b][r] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk_outs("R7 reset");
    rdd("R5 locked data read");
    do_rd(cur_base(), "R5 locked index read");
    idx(8'h07); dat(8'h05);
    chk_outs("R5 locked write ignored");
    // R3: broken sequence
    idx(8'h87); idx(8'h55); idx(8'h87);
    chk({"R3 broken key"}, DW'(cfg_open), DW'(0));
    rdd("R3 still locked");
    idx(8'h87);
    chk("R2 open after two keys", DW'(cfg_open), DW'(1));
    do_rd(cur_base(), "R6 index read");
    idx(8'h07); rdd("R7 ldn reset zero");
    idx(8'hAA);
    chk("R4 locked", DW'(cfg_open), DW'(0));
    // R2: data access between keys
    idx(8'h87); dat(8'h33); rdd("R2 mid read"); idx(8'h87);
    chk("R2 data between keys", DW'(cfg_open), DW'(1));
    do_rd(cur_base(), "R4 index kept across lock");
    // R1 outside window
    do_wr(16'h004E, 8'h20); do_wr(16'h004F, 8'h09);
    do_rd(16'h004F, "R1 outside read");
    chk_outs("R1 outside write ignored");
    // R8
    idx(8'h20); rdd("R8 id"); dat(8'h00); rdd("R8 id after write");
    idx(8'h21); rdd("R8 rev"); dat(8'hFF); rdd("R8 rev after write");
    // R9
    idx(8'h26); dat(8'hBF); rdd("R9 misc strap0");
    idx(8'hAA);
    base_sel = 1;
    unlock(); idx(8'h26); rdd("R9 misc strap1"); dat(8'h00); rdd("R9 misc cleared");
    do_rd(16'h002F, "R1 old base ignored");
    // R10 R11 R12
    idx(8'h07); dat(8'h08); idx(8'h30); dat(8'hFE); rdd("R11 bit0 only");
    dat(8'hFF); rdd("R11 active read"); chk_outs("R11 active out");
    idx(8'hF5); dat(8'hC3); rdd("R12 bank8 byte");
    idx(8'h07); dat(8'h03); idx(8'hF5); rdd("R12 bank3 isolated"); dat(8'h3C);
    chk_outs("R12 packing");
    idx(8'h07); dat(8'h0C); idx(8'hF1); dat(8'h77); rdd("R10 out of range read");
    idx(8'h30); dat(8'h01); rdd("R10 out of range act");
    chk_outs("R10 out of range ignored");
    // R13
    idx(8'h40); dat(8'h99); rdd("R13 unimplemented");
    idx(8'hF0 + 8'(BR)); rdd("R13 past bank range");
    idx(8'hAA); base_sel = 0;
    // random
    for (int i = 0; i < 4000; i++) begin
      int op = $urandom_range(0, 9);
      logic [15:0] a = ($urandom_range(0, 19) == 0) ? 16'($urandom_range(0, 127)) : cur_base();
      if (op < 4) do_wr(a, pick_idx());
      else if (op < 7) do_wr(a | 16'h1, ($urandom_range(0, 3) == 0) ? 8'($urandom_range(0, 12)) : 8'($urandom));
      else do_rd(a | 16'(op & 1), "R6 random read");
      if (i % 50 == 0) chk_outs("R12 random outputs");
      if (i == 2000) base_sel = 1;
    end
    chk_outs("R6 final");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule